// File: doc/BRIEF.md
# Delayed-Write Store Buffer Cache Front End

This block is the front end of a direct-mapped data cache. It lets a store hit finish in a single memory-stage cycle. During its own cycle a store only looks up the tag array. If the store hits, its word address and data are placed in a one-entry pending-write register. The data array is not written then. The pending word is moved into the data array during the tag lookup of the next store that hits, because the array's write port is free in that cycle.

Since array contents trail the stores by one store, a load compares its word address with the pending entry. On a match it returns the pending data in place of the array word. A word-wide refill port installs lines one word per cycle. It also cleans up the pending entry whenever a refill overwrites the line that entry belongs to.

Responses are registered and appear one cycle after the request. Refill cycles and CPU requests never occur in the same cycle.

Top module: `dwc_store_front`

## Requirements
- R1: The byte address is split, from the least significant bit upward, into 2 byte-offset bits, log2(LINE_WORDS) word-select bits (bits [3:2] by default), log2(LINES) index bits ([7:4] by default) and the remaining tag bits. A request accepted in one cycle gives `rsp_valid`=1 in the next cycle, with `rsp_hit`=1 exactly when the indexed line is valid and its stored tag equals the address tag.
- R2: A load that hits the word address of the pending store returns that store's data in the following cycle.
- R3: A store hit writes the previously pending word into the data array in the same cycle, then becomes the pending entry itself. Afterwards, loads of both words return the stored data, including after idle cycles.
- R4: A store that misses reports `rsp_hit`=0, writes nothing and leaves the pending entry unchanged. A later load of the missed address still misses.
- R5: After reset, every line is invalid, nothing is pending and `rsp_valid` is 0 until a request arrives.
- R6: Each cycle with `fill_valid`=1 writes `fill_data` to the word selected by `fill_addr`. A fill cycle with `fill_last`=0 marks the indexed line invalid. A fill cycle with `fill_last`=1 marks it valid with the tag of `fill_addr`. `req_valid` must be 0 whenever `fill_valid` is 1.
- R7: A fill word whose tag, index and word select equal the pending entry writes the pending data in place of `fill_data`, and the pending entry is retired.
- R8: A fill to the pending entry's index with a different tag discards the pending entry, so it is never written into the new line.
- R9: Two store hits to the same word leave the later data visible to loads.
- R10: Loads never change the pending entry or the data array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Previous request hit a valid line |
| rsp_rdata | output | DATA_W | Load data (meaningful on load hits) |
| fill_valid | input | 1 | Refill word present |
| fill_last | input | 1 | Final word of the line; validates the line |
| fill_addr | input | ADDR_W | Byte address of the refill word |
| fill_data | input | DATA_W | Refill word |

## Verification
The hardest case to reach is a refill that meets a live pending store. Either the refill overwrites the very word still held back, or it evicts that line for another tag while the store is still pending. If the pending entry is handled wrongly, the damage only shows later, when a following store hit retires it into the new line. The bench therefore leaves a store pending, refills that line (once with the same tag, once with a new tag), and then issues a store hit elsewhere before loading the affected words.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  // Where a load response takes its data from
  typedef enum logic {
    SRC_ARRAY = 1'b0,
    SRC_PEND  = 1'b1
  } rsp_src_e;
endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] line_tag [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_vld <= '0;
    end else if (wr_en) begin
      line_vld[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) line_tag[wr_idx] <= wr_tag;
  end

  assign lk_hit = line_vld[lk_idx] && (line_tag[lk_idx] == lk_tag);
endmodule

// File: rtl/dwc_data_ram.sv
module dwc_data_ram #(
  parameter int DATA_W = 32,
  parameter int AW     = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dwc_pend_reg.sv
module dwc_pend_reg #(
  parameter int DATA_W = 32,
  parameter int WA_W   = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WA_W-1:0]   load_wa,
  input  logic [DATA_W-1:0] load_data,
  input  logic              clear,
  output logic              vld,
  output logic [WA_W-1:0]   wa,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
    end else if (load) begin
      vld <= 1'b1;
    end else if (clear) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      wa   <= load_wa;
      data <= load_data;
    end
  end
endmodule

// File: rtl/dwc_store_front.sv
module dwc_store_front
  import dwc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              fill_valid,
  input  logic              fill_last,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFF_W;
  localparam int RA_W   = IDX_W + WSEL_W;
  localparam int WA_W   = ADDR_W - BOFF_W;

  // Field extraction
  logic [WA_W-1:0]  req_wa, fill_wa, pend_wa;
  logic [TAG_W-1:0] req_tag, fill_tag, pend_tag;
  logic [IDX_W-1:0] req_idx, fill_idx, pend_idx;
  logic [RA_W-1:0]  req_ra, fill_ra, pend_ra;

  assign req_wa   = req_addr[ADDR_W-1:BOFF_W];
  assign fill_wa  = fill_addr[ADDR_W-1:BOFF_W];
  assign req_tag  = req_wa[WA_W-1 -: TAG_W];
  assign fill_tag = fill_wa[WA_W-1 -: TAG_W];
  assign pend_tag = pend_wa[WA_W-1 -: TAG_W];
  assign req_idx  = req_wa[WSEL_W +: IDX_W];
  assign fill_idx = fill_wa[WSEL_W +: IDX_W];
  assign pend_idx = pend_wa[WSEL_W +: IDX_W];
  assign req_ra   = req_wa[RA_W-1:0];
  assign fill_ra  = fill_wa[RA_W-1:0];
  assign pend_ra  = pend_wa[RA_W-1:0];

  // Tag lookup
  logic hit;
  dwc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (req_idx),
    .lk_tag   (req_tag),
    .lk_hit   (hit),
    .wr_en    (fill_valid),
    .wr_valid (fill_last),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag)
  );

  // Pending delayed write
  logic              pend_vld;
  logic [DATA_W-1:0] pend_data;
  logic              st_hit, ld_req, ld_byp;
  logic              fill_same_word, fill_evicts, pend_clear;

  assign st_hit = req_valid && req_store && hit;
  assign ld_req = req_valid && !req_store;
  assign ld_byp = ld_req && hit && pend_vld && (pend_wa == req_wa);

  assign fill_same_word = fill_valid && pend_vld && (fill_wa == pend_wa);
  assign fill_evicts    = fill_valid && pend_vld && (fill_idx == pend_idx)
                          && (fill_tag != pend_tag);
  assign pend_clear     = fill_same_word || fill_evicts;

  dwc_pend_reg #(.DATA_W(DATA_W), .WA_W(WA_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .load      (st_hit),
    .load_wa   (req_wa),
    .load_data (req_wdata),
    .clear     (pend_clear),
    .vld       (pend_vld),
    .wa        (pend_wa),
    .data      (pend_data)
  );

  // Data array write port: refill first, otherwise retire the pending word
  logic              ram_we;
  logic [RA_W-1:0]   ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = pend_ra;
    ram_wdata = pend_data;
    if (fill_valid) begin
      ram_we    = 1'b1;
      ram_waddr = fill_ra;
      ram_wdata = fill_same_word ? pend_data : fill_data;
    end else if (st_hit && pend_vld) begin
      ram_we    = 1'b1;
    end
  end

  dwc_data_ram #(.DATA_W(DATA_W), .AW(RA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ld_req),
    .raddr (req_ra),
    .rdata (ram_q)
  );

  // Registered response
  rsp_src_e          src_q;
  logic [DATA_W-1:0] byp_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      src_q     <= SRC_ARRAY;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      src_q     <= ld_byp ? SRC_PEND : SRC_ARRAY;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_byp) byp_data_q <= pend_data;
  end

  assign rsp_rdata = (src_q == SRC_PEND) ? byp_data_q : ram_q;

  // R5
  rsp_idle_after_rst_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R4
  miss_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && !hit) |=>
      ($stable(pend_vld) && $stable(pend_wa) && $stable(pend_data)));

  // R3
  retire_on_store_chk: assert property (@(posedge clk) disable iff (rst)
    (st_hit && pend_vld) |-> (ram_we && ram_waddr == pend_ra));

  // R6
  fill_excl_req_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !req_valid);

  // R8
  evict_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && pend_vld && fill_idx == pend_idx && fill_tag != pend_tag)
      |=> !pend_vld);

  // R10
  load_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store) |=> ($stable(pend_vld) && $stable(pend_data)));
endmodule

// File: tb/test_dwc_store_front.sv
module test_dwc_store_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        fill_valid = 1'b0, fill_last = 1'b0;
  logic [31:0] fill_addr = '0, fill_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic        got_hit;
  logic [31:0] got_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwc_store_front i_dwc_store_front (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_valid(fill_valid), .fill_last(fill_last),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  function automatic logic [31:0] mk(input logic [23:0] tag, input logic [3:0] idx,
                                     input logic [1:0] w);
    return {tag, idx, w, 2'b00};
  endfunction

  function automatic logic [31:0] fd(input logic [31:0] a, input logic [15:0] salt);
    return a ^ {salt, 16'h0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request cycle; response captured just after the next rising edge
  task automatic issue(input logic st, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    got_hit = rsp_hit; got_data = rsp_rdata;
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fill_word(input logic [31:0] a, input logic [31:0] d, input logic last);
    fill_valid = 1'b1; fill_addr = a; fill_data = d; fill_last = last;
    @(negedge clk);
    fill_valid = 1'b0; fill_last = 1'b0;
  endtask

  task automatic fill_line(input logic [23:0] tag, input logic [3:0] idx, input logic [15:0] salt);
    for (int w = 0; w < 4; w++)
      fill_word(mk(tag, idx, 2'(w)), fd(mk(tag, idx, 2'(w)), salt), w == 3);
  endtask

  task automatic expect_load(input string req, input logic [31:0] a, input logic [31:0] exp);
    issue(1'b0, a, '0);
    chk({req, " hit"}, {31'b0, got_hit}, 32'd1);
    chk({req, " data"}, got_data, exp);
  endtask

  task automatic expect_miss(input string req, input logic st, input logic [31:0] a);
    issue(st, a, 32'h0BAD_0BAD);
    chk({req, " miss"}, {31'b0, got_hit}, 32'd0);
  endtask

  task automatic expect_store_hit(input string req, input logic [31:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
    chk({req, " store hit"}, {31'b0, got_hit}, 32'd1);
  endtask

  // Scenarios
  task automatic t_reset;
    #1;
    chk("R5 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    expect_miss("R5 cold load", 1'b0, mk(24'h11, 4'd3, 2'd0));
  endtask

  task automatic t_fill_basic;
    fill_line(24'h11, 4'd3, 16'h0001);
    fill_line(24'h22, 4'd6, 16'h0001);
    fill_line(24'h33, 4'd5, 16'h0001);
    for (int w = 0; w < 4; w++)
      expect_load("R1 R6 filled word", mk(24'h11, 4'd3, 2'(w)),
                  fd(mk(24'h11, 4'd3, 2'(w)), 16'h0001));
    expect_miss("R1 tag mismatch", 1'b0, mk(24'h44, 4'd3, 2'd0));
  endtask

  task automatic t_partial_fill;
    fill_word(mk(24'h77, 4'd5, 2'd0), fd(mk(24'h77, 4'd5, 2'd0), 16'h0002), 1'b0);
    fill_word(mk(24'h77, 4'd5, 2'd1), fd(mk(24'h77, 4'd5, 2'd1), 16'h0002), 1'b0);
    idle(1);
    expect_miss("R6 old tag during fill", 1'b0, mk(24'h33, 4'd5, 2'd2));
    expect_miss("R6 new tag during fill", 1'b0, mk(24'h77, 4'd5, 2'd0));
    fill_word(mk(24'h77, 4'd5, 2'd2), fd(mk(24'h77, 4'd5, 2'd2), 16'h0002), 1'b0);
    fill_word(mk(24'h77, 4'd5, 2'd3), fd(mk(24'h77, 4'd5, 2'd3), 16'h0002), 1'b1);
    expect_load("R6 completed line", mk(24'h77, 4'd5, 2'd1), fd(mk(24'h77, 4'd5, 2'd1), 16'h0002));
    expect_miss("R6 evicted tag", 1'b0, mk(24'h33, 4'd5, 2'd0));
  endtask

  task automatic t_bypass;
    expect_store_hit("R2", mk(24'h11, 4'd3, 2'd1), 32'hDEAD_0001);
    expect_load("R2 bypass next cycle", mk(24'h11, 4'd3, 2'd1), 32'hDEAD_0001);
  endtask

  task automatic t_store_miss;
    expect_miss("R4 store", 1'b1, mk(24'h44, 4'd3, 2'd1));
    expect_load("R4 pending kept", mk(24'h11, 4'd3, 2'd1), 32'hDEAD_0001);
    expect_miss("R4 missed addr not installed", 1'b0, mk(24'h44, 4'd3, 2'd1));
  endtask

  task automatic t_retire;
    expect_store_hit("R3", mk(24'h11, 4'd3, 2'd2), 32'hDEAD_0002);
    expect_store_hit("R3", mk(24'h22, 4'd6, 2'd0), 32'hDEAD_00B0);
    expect_load("R3 retired first", mk(24'h11, 4'd3, 2'd1), 32'hDEAD_0001);
    expect_load("R3 retired second", mk(24'h11, 4'd3, 2'd2), 32'hDEAD_0002);
    expect_load("R3 pending third", mk(24'h22, 4'd6, 2'd0), 32'hDEAD_00B0);
    idle(3);
    expect_load("R3 after idle", mk(24'h11, 4'd3, 2'd1), 32'hDEAD_0001);
  endtask

  task automatic t_same_word;
    expect_store_hit("R9", mk(24'h11, 4'd3, 2'd3), 32'h0000_1111);
    expect_store_hit("R9", mk(24'h11, 4'd3, 2'd3), 32'h0000_2222);
    expect_load("R9 later store wins", mk(24'h11, 4'd3, 2'd3), 32'h0000_2222);
    expect_store_hit("R9", mk(24'h22, 4'd6, 2'd1), 32'h0000_3333);
    expect_load("R9 later store retired", mk(24'h11, 4'd3, 2'd3), 32'h0000_2222);
  endtask

  task automatic t_load_transparent;
    expect_load("R10 other word", mk(24'h11, 4'd0 + 4'd3, 2'd0), fd(mk(24'h11, 4'd3, 2'd0), 16'h0001));
    expect_load("R10 other line", mk(24'h77, 4'd5, 2'd0), fd(mk(24'h77, 4'd5, 2'd0), 16'h0002));
    expect_load("R10 pending intact", mk(24'h22, 4'd6, 2'd1), 32'h0000_3333);
    expect_store_hit("R10", mk(24'h22, 4'd6, 2'd2), 32'h0000_4444);
    expect_load("R10 retired intact", mk(24'h22, 4'd6, 2'd1), 32'h0000_3333);
  endtask

  task automatic t_merge;
    fill_line(24'h22, 4'd6, 16'h0003);
    expect_load("R7 merged store kept", mk(24'h22, 4'd6, 2'd2), 32'h0000_4444);
    expect_load("R7 other word refilled", mk(24'h22, 4'd6, 2'd3), fd(mk(24'h22, 4'd6, 2'd3), 16'h0003));
    expect_load("R7 older word refilled", mk(24'h22, 4'd6, 2'd1), fd(mk(24'h22, 4'd6, 2'd1), 16'h0003));
    expect_store_hit("R7", mk(24'h11, 4'd3, 2'd0), 32'h0000_5555);
    expect_load("R7 merged word in array", mk(24'h22, 4'd6, 2'd2), 32'h0000_4444);
  endtask

  task automatic t_evict;
    fill_line(24'h55, 4'd3, 16'h0004);
    expect_store_hit("R8", mk(24'h22, 4'd6, 2'd0), 32'h0000_6666);
    expect_load("R8 new line not corrupted", mk(24'h55, 4'd3, 2'd0), fd(mk(24'h55, 4'd3, 2'd0), 16'h0004));
    expect_miss("R8 old line gone", 1'b0, mk(24'h11, 4'd3, 2'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fill_basic;
    t_partial_fill;
    t_bypass;
    t_store_miss;
    t_retire;
    t_same_word;
    t_load_transparent;
    t_merge;
    t_evict;
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule